// File: doc/BRIEF.md
# Video Interface Mode Register with Direction-Aware Suspend

This block holds the configuration word for a video codec's pixel interface and turns its software-suspend bit into a registered run-enable for the processing pipeline. The host writes the whole word through a simple write strobe and can capture it through a read strobe. The other configuration fields are brought out as a registered vector and as decoded controls: sync pin drive direction, horizontal sync polarity and host interrupt polarity.

Hardware reset leaves the suspend bit set, so nothing runs until the host clears it. When the host sets the suspend bit again, the direction that is in force decides when processing stops. In the compressing (encode) direction the field in progress is allowed to finish, and the pipeline halts after the video timing logic's field-end strobe. In the decompressing (decode) direction it halts at once. A write that changes any mode field while processing is not suspended raises a sticky protocol-error flag.

Top module: `vmr_video_mode_reg`

## Requirements
- R1: After reset the configuration word is 0x0048 (square pixel enable in bit 3 and suspend in bit 6 set, every other bit clear), run-enable is low and the protocol-error flag is low.
- R2: Only bits 8:0 are stored. Bits 15:9, including the reserved top pair 15:14, always read as zero whatever value is written.
- R3: A write that clears the suspend bit (bit 6) raises run-enable on the first clock edge after the write, and run-enable stays high while the suspend bit stays clear.
- R4: When the stored direction bit (bit 2) is 1 (decode) and a write sets the suspend bit while running, run-enable goes low at the same edge that stores the write.
- R5: When the stored direction bit is 0 (encode) and the suspend bit becomes set while running, run-enable stays high until a field-end strobe is sampled and goes low at that edge.
- R6: While the suspend bit is set and run-enable is low, field-end strobes and writes that keep bit 6 set leave run-enable low.
- R7: The horizontal sync polarity output equals bit 7 (1 = sync low during blanking, 0 = high during blanking).
- R8: The host interrupt polarity output equals bit 8 (1 = active high, 0 = active low).
- R9: The sync pin drive-enable output equals bit 0 (1 = master, the block drives the sync pins; 0 = slave, the pins are inputs).
- R10: A write, made while the stored suspend bit is clear, whose bits 8:7 or 5:0 differ from the stored value sets the protocol-error flag one edge later. The flag then stays set until hardware reset.
- R11: A read strobe loads the current configuration word into the read-data output at the next edge. Without a strobe the read data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_i | input | 1 | Write strobe for the configuration word |
| host_wdata_i | input | 16 | Write data |
| host_rd_i | input | 1 | Read strobe |
| host_rdata_o | output | 16 | Captured read data |
| field_end_i | input | 1 | One-cycle strobe at the end of a video field |
| cfg_o | output | 16 | Registered configuration word |
| run_en_o | output | 1 | Processing run-enable |
| sync_drive_o | output | 1 | Drive enable for the sync pins |
| hsync_lo_blank_o | output | 1 | Horizontal sync polarity select |
| irq_act_high_o | output | 1 | Host interrupt polarity select |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The embedded assertions check on every cycle that the reserved bits stay zero, that a clear suspend bit always comes with run-enable high, that decode stops at once and encode stops only at a field-end strobe, and that the error flag never drops. The bench's scenarios are needed to show the complete order of events: encode running on across several idle cycles, strobes being ignored while halted, the exact reset word, and the error appearing only for illegal live changes. These scenarios mix random write, strobe and read traffic with directed corner cases.

// File: rtl/vmr_pkg.sv
// Package: shared field positions and derived constants for the video
// mode register. Assumes a single configuration word of REG_W bits.
package vmr_pkg;
    localparam int REG_W       = 16;
    localparam int B_MASTER    = 0;
    localparam int B_LINES625  = 1;
    localparam int B_DECODE    = 2;
    localparam int B_SQPIX     = 3;
    localparam int B_UNIPOLAR  = 4;
    localparam int B_EXTBIN    = 5;
    localparam int B_SUSPEND   = 6;
    localparam int B_HSYNC_LO  = 7;
    localparam int B_IRQ_HI    = 8;
    localparam int IMPL_BITS   = B_IRQ_HI + 1;

    localparam logic [REG_W-1:0] IMPL_MASK  = REG_W'((1 << IMPL_BITS) - 1);
    localparam logic [REG_W-1:0] MODE_MASK  = IMPL_MASK & ~(REG_W'(1) << B_SUSPEND);
    localparam logic [REG_W-1:0] RESET_WORD = (REG_W'(1) << B_SQPIX) | (REG_W'(1) << B_SUSPEND);
endpackage

// File: rtl/vmr_mode_store.sv
// Module: storage for the configuration word. Keeps only the implemented
// bits; unimplemented and reserved bits are held at zero. Assumes
// host writes are single-cycle strobes.
module vmr_mode_store
    import vmr_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mode_q
);
    // Load the masked write data, or the reset word on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= W'(RESET_WORD);
        else if (wr_i)
            mode_q <= wdata_i & W'(IMPL_MASK);
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q & ~W'(IMPL_MASK)) == '0); // R2
endmodule

// File: rtl/vmr_run_ctrl.sv
// Module: run-enable sequencer. Uses the stored direction to decide
// whether a newly set suspend bit stops at once (decode) or waits for
// the field-end strobe (encode). Assumes field_end_i is a one-cycle pulse.
module vmr_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wr_susp_i,
    input  logic susp_q_i,
    input  logic decode_q_i,
    input  logic field_end_i,
    output logic run_en_o
);
    logic susp_next;

    // Suspend value that will be stored at this edge.
    always_comb susp_next = wr_i ? wr_susp_i : susp_q_i;

    // Update the run-enable from the suspend request and direction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_en_o <= 1'b0;
        else if (!susp_next)
            run_en_o <= 1'b1;
        else if (!run_en_o || decode_q_i || field_end_i)
            run_en_o <= 1'b0;
    end

    AST_CLEAR_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        !susp_q_i |-> run_en_o); // R3
    AST_DEC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_o && decode_q_i && wr_i && wr_susp_i) |=> !run_en_o); // R4
    AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_o && !decode_q_i && !field_end_i) |=> run_en_o); // R5
    AST_ENC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!decode_q_i && field_end_i && susp_q_i && !(wr_i && !wr_susp_i)) |=> !run_en_o); // R5
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en_o && susp_q_i && !(wr_i && !wr_susp_i)) |=> !run_en_o); // R6
endmodule

// File: rtl/vmr_proto_mon.sv
// Module: sticky protocol-error monitor. Flags a write that alters any
// mode field while the stored suspend bit is clear. Assumes the stored
// word is the value before the write takes effect.
module vmr_proto_mon
    import vmr_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] mode_q_i,
    output logic         err_o
);
    logic live_change;

    // Detect a mode-field change written while processing is live.
    always_comb live_change = wr_i && !mode_q_i[B_SUSPEND]
                              && ((wdata_i & W'(MODE_MASK)) != (mode_q_i & W'(MODE_MASK)));

    // Hold the flag once set until hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= 1'b0;
        else if (live_change)
            err_o <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R10
    AST_ERR_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && (!wr_i || mode_q_i[B_SUSPEND])) |=> !err_o); // R10
endmodule

// File: rtl/vmr_video_mode_reg.sv
// Module: top of the video mode register. Joins the word storage, the
// run-enable sequencer and the protocol monitor, decodes the pin
// controls and captures read data on a read strobe. Assumes one host
// access per cycle and a synchronous active-low reset.
module vmr_video_mode_reg
    import vmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_i,
    input  logic [REG_W-1:0] host_wdata_i,
    input  logic             host_rd_i,
    output logic [REG_W-1:0] host_rdata_o,
    input  logic             field_end_i,
    output logic [REG_W-1:0] cfg_o,
    output logic             run_en_o,
    output logic             sync_drive_o,
    output logic             hsync_lo_blank_o,
    output logic             irq_act_high_o,
    output logic             proto_err_o
);
    logic [REG_W-1:0] mode_q;

    vmr_mode_store #(.W(REG_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (host_wr_i),
        .wdata_i (host_wdata_i),
        .mode_q  (mode_q)
    );

    vmr_run_ctrl u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (host_wr_i),
        .wr_susp_i   (host_wdata_i[B_SUSPEND]),
        .susp_q_i    (mode_q[B_SUSPEND]),
        .decode_q_i  (mode_q[B_DECODE]),
        .field_end_i (field_end_i),
        .run_en_o    (run_en_o)
    );

    vmr_proto_mon #(.W(REG_W)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (host_wr_i),
        .wdata_i  (host_wdata_i),
        .mode_q_i (mode_q),
        .err_o    (proto_err_o)
    );

    // Capture the configuration word on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata_o <= '0;
        else if (host_rd_i)
            host_rdata_o <= mode_q;
    end

    // Bring out the word and its decoded pin controls.
    always_comb begin
        cfg_o            = mode_q;
        sync_drive_o     = mode_q[B_MASTER];
        hsync_lo_blank_o = mode_q[B_HSYNC_LO];
        irq_act_high_o   = mode_q[B_IRQ_HI];
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_i |=> $stable(host_rdata_o)); // R11
endmodule

// File: tb/test_vmr_video_mode_reg.sv
// Bench: directed corner cases followed by seeded random traffic, all
// compared against a bench-side model built from the requirements.
module test_vmr_video_mode_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wd = '0;
    logic        rd = 1'b0;
    logic        fe = 1'b0;
    logic [15:0] rdata, cfg;
    logic        run_en, sdrv, hpol, ipol, perr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_cfg, m_rd;
    logic        m_run, m_err;

    vmr_video_mode_reg i_vmr_video_mode_reg (
        .clk(clk), .rst_n(rst_n), .host_wr_i(wr), .host_wdata_i(wd),
        .host_rd_i(rd), .host_rdata_o(rdata), .field_end_i(fe),
        .cfg_o(cfg), .run_en_o(run_en), .sync_drive_o(sdrv),
        .hsync_lo_blank_o(hpol), .irq_act_high_o(ipol), .proto_err_o(perr)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] store_val(input logic [15:0] d);
        return d & 16'h01FF; // R2
    endfunction

    function automatic logic live_err(input logic [15:0] cur, input logic [15:0] d);
        return !cur[6] && ((d & 16'h01BF) != (cur & 16'h01BF)); // R10
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2 cfg", cfg, m_cfg);
        chk("R3/R4/R5/R6 run_en", {15'd0, run_en}, {15'd0, m_run});
        chk("R10 proto_err", {15'd0, perr}, {15'd0, m_err});
        chk("R9 sync_drive", {15'd0, sdrv}, {15'd0, m_cfg[0]});
        chk("R7 hsync_pol", {15'd0, hpol}, {15'd0, m_cfg[7]});
        chk("R8 irq_pol", {15'd0, ipol}, {15'd0, m_cfg[8]});
        chk("R11 rdata", rdata, m_rd);
    endtask

    // One cycle: drive at the falling edge, update the model at the rising
    // edge, compare just after it.
    task automatic step(input logic w, input logic [15:0] d, input logic f, input logic r);
        logic snext;
        wr = w; wd = d; fe = f; rd = r;
        @(posedge clk);
        snext = w ? d[6] : m_cfg[6];
        if (r) m_rd = m_cfg;
        if (w && live_err(m_cfg, d)) m_err = 1'b1;
        if (!snext) m_run = 1'b1;
        else if (!m_run || m_cfg[2] || f) m_run = 1'b0;
        if (w) m_cfg = store_val(d);
        #1;
        check_all();
        @(negedge clk);
        wr = 1'b0; fe = 1'b0; rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        m_cfg = 16'h0048; m_run = 1'b0; m_err = 1'b0; m_rd = 16'h0000;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        // R1: reset word and quiet outputs
        chk("R1 reset cfg", cfg, 16'h0048);
        chk("R1 reset run", {15'd0, run_en}, 16'd0);
        chk("R1 reset err", {15'd0, perr}, 16'd0);
        // R6: strobes while halted leave run low
        step(1'b0, 16'h0, 1'b1, 1'b0);
        step(1'b1, 16'h0048, 1'b1, 1'b1);
        // R2: reserved bits dropped (suspend kept set)
        step(1'b1, 16'hFFFF, 1'b0, 1'b1);
        chk("R2 reserved zero", cfg & 16'hFE00, 16'h0000);
        // Encode, then run: R3
        step(1'b1, 16'h01C9, 1'b0, 1'b0);
        step(1'b1, 16'h0189, 1'b0, 1'b0);
        chk("R3 run after clear", {15'd0, run_en}, 16'd1);
        // R5: suspend in encode holds until strobe
        step(1'b1, 16'h01C9, 1'b0, 1'b0);
        step(1'b0, 16'h0, 1'b0, 1'b0);
        step(1'b0, 16'h0, 1'b0, 1'b0);
        chk("R5 encode holds", {15'd0, run_en}, 16'd1);
        step(1'b0, 16'h0, 1'b1, 1'b0);
        chk("R5 encode stops at strobe", {15'd0, run_en}, 16'd0);
        // Switch to decode while suspended, run, then suspend: R4
        step(1'b1, 16'h004C, 1'b0, 1'b0);
        step(1'b1, 16'h000C, 1'b0, 1'b1);
        step(1'b1, 16'h004C, 1'b0, 1'b0);
        chk("R4 decode stops at once", {15'd0, run_en}, 16'd0);
        chk("R10 no error yet", {15'd0, perr}, 16'd0);
        // R10: live mode change while running
        step(1'b1, 16'h000C, 1'b0, 1'b0);
        step(1'b1, 16'h000D, 1'b0, 1'b0);
        chk("R10 error set", {15'd0, perr}, 16'd1);
        do_reset();
        // Random traffic, suspend set most of the time
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            logic w;
            d = 16'($urandom);
            w = ($urandom % 4) == 0;
            if (($urandom % 3) != 0) d[6] = 1'b1;
            if (($urandom % 2) == 0 && !m_cfg[6]) d = (m_cfg & 16'h01BF) | (d & 16'hFE40);
            step(w, d, ($urandom % 8) == 0, ($urandom % 4) == 0);
            if (($urandom % 500) == 0) do_reset();
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule